// File: doc/BRIEF.md
# Instruction-Fetch Address Remap Unit

This block sits between the CPU instruction-fetch port and the memory system. It holds a small file of match entries, one per RAM block. Each entry names a window of flash address space. When a fetch lands in the window of an active entry, the unit redirects the fetch into that entry's RAM block and keeps the offset inside the block. It also marks the access as non-cacheable, because RAM answers about as fast as the cache would. A fetch that misses every entry goes out unchanged and stays cacheable.

Software programs each entry one byte at a time over a plain register bus, using three byte registers per entry. The top byte also carries a mode bit. Software sets that bit while it copies code into the RAM block, and clears it in the final write that turns the remap on. Entries 0 to 15 each cover 4 KB, entries 16 to 19 each cover 16 KB, and entries 20 to 23 each cover 32 KB. The RAM blocks sit back to back from the RAM base in entry order. Translation is combinational from the fetch address and the stored entries.

Top module: `remap_fetch_unit`

## Requirements
- R1: After reset, every entry reads back 0x00 in the low and middle bytes and 0x08 in the high byte, and no fetch is redirected.
- R2: The register address is {entry index, byte select}. Select 0 is the low byte and holds match address bits 7:0. Select 1 is the middle byte and holds bits 15:8. Select 2 is the high byte: its bits 2:0 hold address bits 18:16, bit 7 holds address bit 19 and bit 3 is the mode bit. Reads return the stored byte exactly as written. Select 3 and entry indices of 24 or more read as 0x00.
- R3: A register write changes the read data and the translation on the clock edge that follows the write, and not before it.
- R4: An entry whose mode bit (high byte bit 3) is set never hits.
- R5: A 4 KB entry i hits for fetch offsets in [A, A+0x1000), where A is its match address. The output is RAM_BASE + i*0x1000 + (offset & 0xFFF). An offset of A+0x1000 or A-1 misses.
- R6: An entry whose match address has any of bits 11:0 nonzero never hits.
- R7: Only bits 19:0 of the fetch address take part in the compare. Bits 31:20 do not change the hit or the translated address.
- R8: A hit drives the hit flag to 1, the cacheable flag to 0 and the entry index. A miss drives the hit flag to 0, the cacheable flag to 1, the output address equal to the fetch address and the index to 0.
- R9: Entries 16 to 19 compare address bits 19:14 and map to RAM_BASE + 0x10000 + (i-16)*0x4000. Entries 20 to 23 compare bits 19:15 and map to RAM_BASE + 0x20000 + (i-20)*0x8000. Match address bits below the window size but at or above bit 12 are ignored in the compare.
- R10: When several active entries match one fetch, the lowest-numbered entry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | {entry index[6:2], byte select[1:0]} |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte for reg_addr (combinational) |
| fetch_addr | input | 32 | Instruction fetch address |
| xlat_addr | output | 32 | Translated or passed-through address |
| xlat_hit | output | 1 | Fetch was redirected to RAM |
| xlat_idx | output | 5 | Index of the winning entry |
| xlat_cacheable | output | 1 | Access may be cached |

## Verification
The bench probes the window edges: the last byte inside a window, the first byte past it and the byte just below it. A design with an off-by-one in the compare mask would hit or miss at the wrong one of these. It programs address bit 19 through the high byte's bit 7, so a design that takes bit 3 as the address bit would send the fetch to the wrong block. It also sets only the low bits, or only the mode bit, on otherwise valid entries, and overlaps two entries on one window. A design that skips the alignment check, inverts the mode sense or scans the entries from the top down would report a hit or the wrong entry index. It then checks the wide entries, where a wrong RAM offset for the larger blocks or a compare of too many bits would show up in the translated address.

// File: rtl/remap_pkg.sv
package remap_pkg;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_MID  = 2'd1,
        SEL_HI   = 2'd2,
        SEL_NONE = 2'd3
    } byte_sel_e;

    localparam int MODE_BIT   = 3;
    localparam int ADDR19_BIT = 7;
    localparam int OFFS_W     = 20;
    localparam logic [7:0] HI_RESET = 8'h08;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] mid;
        logic [7:0] lo;
    } entry_regs_t;

    // Window size (log2 bytes) of entry idx under the tiered geometry.
    function automatic int win_log2(int idx, int n_small, int n_mid,
                                     int blk_lg, int mid_lg, int big_lg);
        if (idx < n_small)
            return blk_lg;
        else if (idx < n_small + n_mid)
            return mid_lg;
        else
            return big_lg;
    endfunction

    // Byte offset of entry idx's RAM block from the RAM base.
    function automatic logic [31:0] ram_offset(int idx, int n_small, int n_mid,
                                               int blk_lg, int mid_lg, int big_lg);
        logic [31:0] off;
        if (idx < n_small)
            off = 32'(idx) << blk_lg;
        else if (idx < n_small + n_mid)
            off = (32'(n_small) << blk_lg) + (32'(idx - n_small) << mid_lg);
        else
            off = (32'(n_small) << blk_lg) + (32'(n_mid) << mid_lg)
                + (32'(idx - n_small - n_mid) << big_lg);
        return off;
    endfunction

    // Reassemble the 20-bit match address from the three stored bytes.
    function automatic logic [OFFS_W-1:0] match_addr(entry_regs_t e);
        return {e.hi[ADDR19_BIT], e.hi[2:0], e.mid, e.lo};
    endfunction

endpackage

// File: rtl/remap_entry_file.sv
module remap_entry_file
    import remap_pkg::*;
#(
    parameter int NUM_ENTRIES = 24,
    parameter int IDX_W       = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [IDX_W-1:0]              ent,
    input  byte_sel_e                     sel,
    input  logic [7:0]                    wdata,
    output logic [7:0]                    rdata,
    output entry_regs_t [NUM_ENTRIES-1:0] regs
);

    logic ent_ok;
    assign ent_ok = {1'b0, ent} < (IDX_W+1)'(NUM_ENTRIES);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENTRIES; i++)
                regs[i] <= '{hi: HI_RESET, mid: 8'h00, lo: 8'h00};
        end else if (we && ent_ok) begin
            case (sel)
                SEL_LO:  regs[ent].lo  <= wdata;
                SEL_MID: regs[ent].mid <= wdata;
                SEL_HI:  regs[ent].hi  <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (ent_ok) begin
            case (sel)
                SEL_LO:  rdata = regs[ent].lo;
                SEL_MID: rdata = regs[ent].mid;
                SEL_HI:  rdata = regs[ent].hi;
                default: rdata = 8'h00;
            endcase
        end
    end

    // R3: a write is visible in the stored entry on the following cycle
    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we && ent_ok && sel == SEL_HI) |=> regs[$past(ent)].hi == $past(wdata));

endmodule

// File: rtl/remap_matcher.sv
module remap_matcher
    import remap_pkg::*;
#(
    parameter int NUM_ENTRIES = 24,
    parameter int N_SMALL     = 16,
    parameter int N_MID       = 4,
    parameter int BLK_LG      = 12,
    parameter int MID_LG      = 14,
    parameter int BIG_LG      = 15
) (
    input  entry_regs_t [NUM_ENTRIES-1:0] regs,
    input  logic [OFFS_W-1:0]             fetch_off,
    output logic [NUM_ENTRIES-1:0]        match
);

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
        localparam int WL = win_log2(i, N_SMALL, N_MID, BLK_LG, MID_LG, BIG_LG);
        localparam logic [OFFS_W-1:0] CMP_MASK = ~OFFS_W'((1 << WL) - 1);
        logic [OFFS_W-1:0] base;
        logic active, aligned;
        assign base    = match_addr(regs[i]);
        assign active  = ~regs[i].hi[MODE_BIT];
        assign aligned = (base[BLK_LG-1:0] == '0);
        assign match[i] = active && aligned
                       && ((fetch_off & CMP_MASK) == (base & CMP_MASK));
    end

endmodule

// File: rtl/remap_select.sv
module remap_select
    import remap_pkg::*;
#(
    parameter int          NUM_ENTRIES = 24,
    parameter int          IDX_W       = 5,
    parameter int          N_SMALL     = 16,
    parameter int          N_MID       = 4,
    parameter int          BLK_LG      = 12,
    parameter int          MID_LG      = 14,
    parameter int          BIG_LG      = 15,
    parameter logic [31:0] RAM_BASE    = 32'h8010_0000
) (
    input  logic [NUM_ENTRIES-1:0] match,
    input  logic [31:0]            fetch_addr,
    output logic [31:0]            out_addr,
    output logic                   out_hit,
    output logic [IDX_W-1:0]       out_idx,
    output logic                   out_cacheable
);

    logic [NUM_ENTRIES-1:0][31:0] xlate;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_xl
        localparam int WL = win_log2(i, N_SMALL, N_MID, BLK_LG, MID_LG, BIG_LG);
        localparam logic [31:0] BLK_BASE =
            RAM_BASE + ram_offset(i, N_SMALL, N_MID, BLK_LG, MID_LG, BIG_LG);
        localparam logic [31:0] IN_MASK = 32'((1 << WL) - 1);
        assign xlate[i] = BLK_BASE + (fetch_addr & IN_MASK);
    end

    // Scan from the top so the lowest matching index is the last to assign.
    always_comb begin
        out_addr      = fetch_addr;
        out_hit       = 1'b0;
        out_idx       = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                out_addr = xlate[i];
                out_hit  = 1'b1;
                out_idx  = IDX_W'(i);
            end
        end
        out_cacheable = ~out_hit;
    end

endmodule

// File: rtl/remap_fetch_unit.sv
module remap_fetch_unit
    import remap_pkg::*;
#(
    parameter int          NUM_ENTRIES = 24,
    parameter int          N_SMALL     = 16,
    parameter int          N_MID       = 4,
    parameter int          BLK_LG      = 12,
    parameter int          MID_LG      = 14,
    parameter int          BIG_LG      = 15,
    parameter logic [31:0] RAM_BASE    = 32'h8010_0000,
    localparam int         IDX_W       = $clog2(NUM_ENTRIES),
    localparam int         RA_W        = IDX_W + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [31:0]      fetch_addr,
    output logic [31:0]      xlat_addr,
    output logic             xlat_hit,
    output logic [IDX_W-1:0] xlat_idx,
    output logic             xlat_cacheable
);

    entry_regs_t [NUM_ENTRIES-1:0] regs;
    logic [NUM_ENTRIES-1:0]        match;

    remap_entry_file #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_file (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .ent   (reg_addr[RA_W-1:2]),
        .sel   (byte_sel_e'(reg_addr[1:0])),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .regs  (regs)
    );

    remap_matcher #(
        .NUM_ENTRIES(NUM_ENTRIES), .N_SMALL(N_SMALL), .N_MID(N_MID),
        .BLK_LG(BLK_LG), .MID_LG(MID_LG), .BIG_LG(BIG_LG)
    ) u_match (
        .regs      (regs),
        .fetch_off (fetch_addr[OFFS_W-1:0]),
        .match     (match)
    );

    remap_select #(
        .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .N_SMALL(N_SMALL), .N_MID(N_MID),
        .BLK_LG(BLK_LG), .MID_LG(MID_LG), .BIG_LG(BIG_LG), .RAM_BASE(RAM_BASE)
    ) u_sel (
        .match         (match),
        .fetch_addr    (fetch_addr),
        .out_addr      (xlat_addr),
        .out_hit       (xlat_hit),
        .out_idx       (xlat_idx),
        .out_cacheable (xlat_cacheable)
    );

    // R1: nothing is redirected on the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !xlat_hit);

    // R8: a miss passes the fetch through and keeps it cacheable
    a_r8_miss_passthru: assert property (@(posedge clk) disable iff (rst)
        !xlat_hit |-> (xlat_cacheable && xlat_addr == fetch_addr));

    // R8: a hit is never cacheable
    a_r8_hit_uncached: assert property (@(posedge clk) disable iff (rst)
        xlat_hit |-> !xlat_cacheable);

    // R4 and R6: the winning entry is active and block aligned
    a_r4_r6_winner_valid: assert property (@(posedge clk) disable iff (rst)
        xlat_hit |-> (!regs[xlat_idx].hi[MODE_BIT] && regs[xlat_idx].lo == 8'h00
                      && regs[xlat_idx].mid[3:0] == 4'h0));

    // R10: the reported entry matches and no lower entry does
    a_r10_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        xlat_hit |-> (match[xlat_idx]
                      && (match & ((NUM_ENTRIES'(1) << xlat_idx) - NUM_ENTRIES'(1))) == '0));

endmodule

// File: tb/remap_fetch_unit_tb.sv
module remap_fetch_unit_tb_top;

    localparam logic [31:0] RB = 32'h8010_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [31:0] fetch_addr = '0;
    logic [31:0] xlat_addr;
    logic        xlat_hit;
    logic [4:0]  xlat_idx;
    logic        xlat_cacheable;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    remap_fetch_unit dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_addr(fetch_addr),
        .xlat_addr(xlat_addr), .xlat_hit(xlat_hit), .xlat_idx(xlat_idx),
        .xlat_cacheable(xlat_cacheable)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(int ent, int sel, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 7'((ent << 2) | sel); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(string req, int ent, int sel, logic [7:0] exp);
        reg_addr = 7'((ent << 2) | sel);
        #1;
        chk(req, "read", 32'(reg_rdata), 32'(exp));
    endtask

    task automatic prog(int ent, logic [19:0] a, logic [7:0] lo_extra);
        wr(ent, 0, a[7:0] | lo_extra);
        wr(ent, 1, a[15:8]);
        wr(ent, 2, {a[19], 4'b0000, a[18:16]});
    endtask

    task automatic f_chk(string req, logic [31:0] fa, bit hit, int idx, logic [31:0] exp_a);
        fetch_addr = fa;
        #1;
        chk(req, "hit", 32'(xlat_hit), 32'(hit));
        chk(req, "cacheable", 32'(xlat_cacheable), 32'(!hit));
        chk(req, "addr", xlat_addr, hit ? exp_a : fa);
        chk(req, "idx", 32'(xlat_idx), hit ? 32'(idx) : 32'd0);
    endtask

    task automatic t_reset();
        rd_chk("R1", 0, 0, 8'h00);
        rd_chk("R1", 0, 1, 8'h00);
        rd_chk("R1", 0, 2, 8'h08);
        rd_chk("R1", 23, 2, 8'h08);
        f_chk("R1", 32'h0000_0000, 0, 0, 0);
        f_chk("R1", 32'h0002_1000, 0, 0, 0);
    endtask

    task automatic t_layout();
        wr(2, 0, 8'h34);
        wr(2, 1, 8'h12);
        wr(2, 2, 8'hF8);
        rd_chk("R2", 2, 0, 8'h34);
        rd_chk("R2", 2, 1, 8'h12);
        rd_chk("R2", 2, 2, 8'hF8);
        rd_chk("R2", 2, 3, 8'h00);
        rd_chk("R2", 25, 0, 8'h00);
        wr(2, 0, 8'h00);
        wr(2, 2, 8'h08);
    endtask

    task automatic t_next_cycle();
        wr(0, 0, 8'h00);
        wr(0, 1, 8'h10);
        fetch_addr = 32'h0002_1000;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 7'(2); reg_wdata = 8'h02;
        #1;
        chk("R3", "hit before edge", 32'(xlat_hit), 32'd0);
        chk("R3", "read before edge", 32'(reg_rdata), 32'h08);
        @(posedge clk);
        #1;
        reg_we = 1'b0;
        chk("R3", "hit after edge", 32'(xlat_hit), 32'd1);
        chk("R3", "read after edge", 32'(reg_rdata), 32'h02);
    endtask

    task automatic t_window4k();
        f_chk("R5", 32'h0002_1000, 1, 0, RB);
        f_chk("R5", 32'h0002_1FFF, 1, 0, RB + 32'hFFF);
        f_chk("R5", 32'h0002_2000, 0, 0, 0);
        f_chk("R5", 32'h0002_0FFF, 0, 0, 0);
        f_chk("R7", 32'h8002_1ABC, 1, 0, RB + 32'hABC);
        f_chk("R7", 32'hFFF2_1004, 1, 0, RB + 32'h004);
        // address bit 19 lives in high-byte bit 7
        prog(3, 20'h9_5000, 8'h00);
        f_chk("R2", 32'h0009_5010, 1, 3, RB + 32'h3010);
        f_chk("R2", 32'h0001_5010, 0, 0, 0);
    endtask

    task automatic t_mode();
        wr(0, 2, 8'h0A);
        f_chk("R4", 32'h0002_1000, 0, 0, 0);
        wr(0, 2, 8'h02);
        f_chk("R4", 32'h0002_1000, 1, 0, RB);
    endtask

    task automatic t_lowbits();
        prog(1, 20'h3_0000, 8'h04);
        rd_chk("R2", 1, 0, 8'h04);
        f_chk("R6", 32'h0003_0000, 0, 0, 0);
        f_chk("R6", 32'h0003_0004, 0, 0, 0);
        wr(1, 0, 8'h00);
        f_chk("R6", 32'h0003_0004, 1, 1, RB + 32'h1004);
    endtask

    task automatic t_priority();
        prog(5, 20'h2_1000, 8'h00);
        f_chk("R10", 32'h0002_1100, 1, 0, RB + 32'h100);
        wr(0, 2, 8'h08);
        f_chk("R10", 32'h0002_1100, 1, 5, RB + 32'h5100);
    endtask

    task automatic t_wide();
        prog(16, 20'h4_0000, 8'h00);
        f_chk("R9", 32'h0004_3FFC, 1, 16, RB + 32'h1_3FFC);
        f_chk("R9", 32'h0004_4000, 0, 0, 0);
        prog(21, 20'h6_3000, 8'h00);
        f_chk("R9", 32'h0006_7000, 1, 21, RB + 32'h2_F000);
        f_chk("R9", 32'h0006_0000, 1, 21, RB + 32'h2_8000);
        f_chk("R9", 32'h0006_8000, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_layout();
        t_next_cycle();
        t_window4k();
        t_mode();
        t_lowbits();
        t_priority();
        t_wide();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule